// File: doc/BRIEF.md
# Shared RAM/ROM Bus Strobe Sequencer

The block sits on the host side of an asynchronous memory that joins a static RAM and a mask ROM on one address bus and one 8-bit data bus. A host issues one request at a time on a valid/ready handshake. Each request carries a target (RAM or ROM), a direction, an address and write data. The block then plays out the chip-select, write-enable and output-enable strobes for that request. Every interval is a whole number of system clocks, and each count is a parameter. The defaults suit a 50 MHz clock and the fastest supply class of the memory.

The two arrays have cycle lengths of their own. The ROM cycle is longer than the RAM cycle. On a read, the block releases its data drivers before output enable falls. It captures the bus on the last clock of the access and returns the byte with a one-cycle valid pulse. The bus then stays released for a turnaround period before another request can be taken. A write to the ROM is impossible, so such a request is carried out as a ROM read with write enable held high. Only one select is ever active, and at least one clock with both selects inactive separates two accesses.

Top module: `shbus_seq`

## Requirements
- R1: Out of reset, req_ready is 1, ram_sel_n, rom_sel_n, we_n and oe_n are all 1, rd_valid is 0 and the block does not drive mem_data.
- R2: A RAM read (req_rom=0, req_write=0) holds ram_sel_n low for exactly RAM_CYC (default 5) consecutive clocks while rom_sel_n and we_n stay high. rd_data then carries the value on mem_data in the last of those clocks, and rd_valid is 1 for exactly one clock.
- R3: A ROM read (req_rom=1) holds rom_sel_n low for exactly ROM_CYC (default 8) consecutive clocks while ram_sel_n stays high. It returns the byte the same way as R2.
- R4: On every read, oe_n is high in the first clock of the access and low in each remaining clock of that access. On a write, oe_n stays high.
- R5: A RAM write (req_rom=0, req_write=1) holds ram_sel_n low for RAM_CYC clocks. we_n is low for the first WP_CYC (default 4) of those clocks and high for the rest. mem_data carries req_wdata in every clock in which we_n is low.
- R6: A request with req_rom=1 and req_write=1 behaves as a ROM read. we_n is never low while rom_sel_n is low.
- R7: ram_sel_n and rom_sel_n are never low together. When req_ready returns high, both are high.
- R8: req_ready is low from the clock after acceptance until the request finishes: RAM_CYC clocks for a write, and RAM_CYC or ROM_CYC plus TURN_CYC (default 2) clocks for a read. A req_valid raised while req_ready is low and dropped before it rises has no effect on memory contents.
- R9: mem_addr equals the accepted address and is stable for every clock in which a select is low.
- R10: The block never drives mem_data while oe_n is low, so mem_data carries only the memory's value in those clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_rom | input | 1 | 1 targets ROM, 0 targets RAM |
| req_write | input | 1 | 1 requests a write (RAM only) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Byte returned by the last read |
| rd_valid | output | 1 | One-clock pulse marking rd_data as new |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_data | inout | DATA_W | Shared bidirectional data pins |
| ram_sel_n | output | 1 | RAM select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that the memory drives mem_data only while oe_n is low, write enable is high and a select is active. They also assume that the host changes req_valid and the request fields only away from the rising clock edge. The bench memory model drives the bus only under exactly that condition. All request inputs are changed on the falling edge. Random requests mix RAM reads, RAM writes, ROM reads and ROM requests with the write flag set, and RAM addresses stay within the model's 4096 bytes. A directed case raises req_valid while a transfer is busy.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACC   = 2'd1,
        ST_FLOAT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/shbus_timer.sv
module shbus_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = '0;
            tmr_d.lim = lim;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign cnt  = tmr_q.cnt;
    assign last = (tmr_q.cnt == tmr_q.lim - 1'b1);

endmodule

// File: rtl/shbus_pad.sv
module shbus_pad #(
    parameter int W = 8
) (
    input  logic         drv,
    input  logic [W-1:0] dout,
    output logic [W-1:0] din,
    inout  wire  [W-1:0] pad
);

    assign pad = drv ? dout : {W{1'bz}};
    assign din = pad;

endmodule

// File: rtl/shbus_seq.sv
module shbus_seq
    import shbus_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter int RAM_CYC  = 5,
    parameter int ROM_CYC  = 8,
    parameter int WP_CYC   = 4,
    parameter int TURN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_rom,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_data,
    output logic              ram_sel_n,
    output logic              rom_sel_n,
    output logic              we_n,
    output logic              oe_n
);

    localparam int MAX_CYC = (ROM_CYC > RAM_CYC) ? ROM_CYC : RAM_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

    typedef struct packed {
        seq_state_e        st;
        logic              is_rom;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_s;

    seq_s seq_d, seq_q;

    logic             t_start;
    logic [CNT_W-1:0] t_lim;
    logic [CNT_W-1:0] t_cnt;
    logic             t_last;
    logic [DATA_W-1:0] bus_in;
    logic             drv_en;
    logic             in_acc;

    shbus_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .lim   (t_lim),
        .cnt   (t_cnt),
        .last  (t_last)
    );

    shbus_pad #(.W(DATA_W)) u_pad (
        .drv  (drv_en),
        .dout (seq_q.wdata),
        .din  (bus_in),
        .pad  (mem_data)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        t_start      = 1'b0;
        t_lim        = CNT_W'(RAM_CYC);
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st     = ST_ACC;
                    seq_d.is_rom = req_rom;
                    seq_d.is_wr  = req_write & ~req_rom;
                    seq_d.addr   = req_addr;
                    seq_d.wdata  = req_wdata;
                    t_start      = 1'b1;
                    t_lim        = req_rom ? CNT_W'(ROM_CYC) : CNT_W'(RAM_CYC);
                end
            end
            ST_ACC: begin
                if (t_last) begin
                    if (seq_q.is_wr) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.st     = ST_FLOAT;
                        seq_d.rdata  = bus_in;
                        seq_d.rvalid = 1'b1;
                        t_start      = 1'b1;
                        t_lim        = CNT_W'(TURN_CYC);
                    end
                end
            end
            ST_FLOAT: begin
                if (t_last) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_acc    = (seq_q.st == ST_ACC);
    assign req_ready = (seq_q.st == ST_IDLE);
    assign ram_sel_n = ~(in_acc & ~seq_q.is_rom);
    assign rom_sel_n = ~(in_acc &  seq_q.is_rom);
    assign we_n      = ~(in_acc & seq_q.is_wr & (t_cnt < CNT_W'(WP_CYC)));
    assign oe_n      = ~(in_acc & ~seq_q.is_wr & (t_cnt != '0));
    assign drv_en    = in_acc & seq_q.is_wr;
    assign mem_addr  = seq_q.addr;
    assign rd_data   = seq_q.rdata;
    assign rd_valid  = seq_q.rvalid;

    // R7: the two selects are never active together
    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_sel_n && !rom_sel_n));

    // R6: write enable stays high during any ROM access
    a_r6_rom_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel_n |-> we_n);

    // R10: own drivers are off while the memory may drive
    a_r10_no_drive_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !drv_en);

    // R9: address held while a select stays low
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ram_sel_n || !rom_sel_n) && $past(!ram_sel_n || !rom_sel_n)) |-> $stable(mem_addr));

    // R2: read-data valid is a single-cycle pulse
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8: no acceptance while an access is in progress
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_sel_n || !rom_sel_n) |-> !req_ready);

    // R5: a write pulse begins together with the select
    a_r5_we_with_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $fell(ram_sel_n));

endmodule

// File: tb/sim_shbus_seq.sv
module sim_shbus_seq;

    localparam int AW = 18;
    localparam int DW = 8;
    localparam int RAM_C = 5;
    localparam int ROM_C = 8;
    localparam int WP_C = 4;
    localparam int TURN_C = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_rom = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, ram_sel_n, rom_sel_n, we_n, oe_n;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [DW-1:0] ram_m   [0:4095];
    logic [DW-1:0] exp_ram [0:4095];

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] rom_val(input logic [AW-1:0] a);
        return a[7:0] ^ {a[15:10], a[17:16]} ^ 8'h5a;
    endfunction

    assign mem_data = (!oe_n && we_n && !ram_sel_n) ? ram_m[mem_addr[11:0]] :
                      (!oe_n && we_n && !rom_sel_n) ? rom_val(mem_addr) : {DW{1'bz}};

    always @(posedge we_n) begin
        if (ram_sel_n === 1'b0) ram_m[mem_addr[11:0]] <= mem_data;
    end

    shbus_seq #(
        .ADDR_W(AW), .DATA_W(DW), .RAM_CYC(RAM_C), .ROM_CYC(ROM_C),
        .WP_CYC(WP_C), .TURN_CYC(TURN_C)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rom(req_rom), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .ram_sel_n(ram_sel_n),
        .rom_sel_n(rom_sel_n), .we_n(we_n), .oe_n(oe_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One request, monitored clock by clock on falling edges.
    task automatic run_op(input bit rom, input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input bit poke,
                          input logic [AW-1:0] poke_a);
        int busy = 0, nram = 0, nrom = 0, nwe = 0, noe = 0, nrv = 0;
        int first_oe = -1, bad_addr = 0, bad_wd = 0, xbus = 0, dual = 0, rom_we = 0;
        logic [DW-1:0] got = '0;
        logic [DW-1:0] exp_d;
        bit eff_wr = wr && !rom;
        int exp_busy;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_rom = rom; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            if (poke && busy == 1) begin
                req_valid = 1'b1; req_rom = 1'b0; req_write = 1'b1;
                req_addr = poke_a; req_wdata = ~exp_ram[poke_a[11:0]];
            end
            if (poke && busy == 3) req_valid = 1'b0;
            if (!ram_sel_n) nram++;
            if (!rom_sel_n) nrom++;
            if (!ram_sel_n && !rom_sel_n) dual++;
            if (!we_n) begin
                nwe++;
                if (mem_data !== wd) bad_wd++;
                if (!rom_sel_n) rom_we++;
            end
            if (!oe_n) begin
                noe++;
                if (first_oe < 0) first_oe = busy;
                if ($isunknown(mem_data)) xbus++;
            end
            if ((!ram_sel_n || !rom_sel_n) && mem_addr !== a) bad_addr++;
            if (rd_valid) begin nrv++; got = rd_data; end
            busy++;
            @(negedge clk);
        end
        exp_busy = eff_wr ? RAM_C : ((rom ? ROM_C : RAM_C) + TURN_C);
        chk(busy == exp_busy, "R8 busy length", busy, exp_busy);
        chk(dual == 0, "R7 dual select", dual, 0);
        chk(ram_sel_n && rom_sel_n, "R7 idle selects", {ram_sel_n, rom_sel_n}, 3);
        chk(bad_addr == 0, "R9 address stable", bad_addr, 0);
        chk(xbus == 0, "R10 bus clean under oe", xbus, 0);
        if (rom) begin
            chk(nrom == ROM_C, "R3 rom select length", nrom, ROM_C);
            chk(nram == 0, "R3 ram select idle", nram, 0);
            chk(nwe == 0 && rom_we == 0, "R6 we high on rom", nwe, 0);
        end else begin
            chk(nram == RAM_C, "R2 ram select length", nram, RAM_C);
            chk(nrom == 0, "R2 rom select idle", nrom, 0);
        end
        if (eff_wr) begin
            chk(nwe == WP_C, "R5 write pulse", nwe, WP_C);
            chk(bad_wd == 0, "R5 write data on bus", bad_wd, 0);
            chk(noe == 0, "R4 oe high on write", noe, 0);
            chk(nrv == 0, "R2 no valid on write", nrv, 0);
            exp_ram[a[11:0]] = wd;
        end else begin
            exp_d = rom ? rom_val(a) : exp_ram[a[11:0]];
            chk(nwe == 0, "R2 we high on read", nwe, 0);
            chk(noe == (rom ? ROM_C : RAM_C) - 1, "R4 oe count", noe, (rom ? ROM_C : RAM_C) - 1);
            chk(first_oe == 1, "R4 oe first clock", first_oe, 1);
            chk(nrv == 1, "R2 valid pulse count", nrv, 1);
            chk(got == exp_d, rom ? "R3 rom data" : "R2 ram data", got, exp_d);
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            ram_m[i] = '0;
            exp_ram[i] = '0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
        chk({ram_sel_n, rom_sel_n, we_n, oe_n} === 4'hf, "R1 strobes", {ram_sel_n, rom_sel_n, we_n, oe_n}, 15);
        chk(rd_valid === 1'b0, "R1 valid", rd_valid, 0);
        chk(mem_data === 8'hzz, "R1 bus released", mem_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_op(1'b0, 1'b1, 18'h0,     8'ha5, 1'b0, '0);
        run_op(1'b0, 1'b1, 18'h0fff,  8'h3c, 1'b0, '0);
        run_op(1'b0, 1'b0, 18'h0,     8'h00, 1'b0, '0);
        run_op(1'b0, 1'b0, 18'h0fff,  8'h00, 1'b0, '0);
        run_op(1'b1, 1'b1, 18'h3ffff, 8'hff, 1'b0, '0);   // R6 rom with write flag
        run_op(1'b1, 1'b0, 18'h00000, 8'h00, 1'b0, '0);
        run_op(1'b0, 1'b0, 18'h0123,  8'h00, 1'b0, '0);   // rom then ram switch
        // R8 request raised while busy must not take effect
        run_op(1'b0, 1'b0, 18'h0fff,  8'h00, 1'b1, 18'h0010);
        run_op(1'b0, 1'b0, 18'h0010,  8'h00, 1'b0, '0);
        chk(ram_m[12'h010] === 8'h00, "R8 ignored write", ram_m[12'h010], 0);
        // constrained random
        for (int k = 0; k < 60; k++) begin
            logic [AW-1:0] a;
            bit rom, wr;
            rom = ($urandom % 3) == 0;
            wr  = ($urandom % 2) == 0;
            a   = rom ? AW'($urandom) : AW'($urandom % 4096);
            run_op(rom, wr, a, DW'($urandom), 1'b0, '0);
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule